// File: doc/BRIEF.md
# Filtered Quadrature Position Counter with Index Clear

This block turns the A, B, Index and Index-Mask lines of an incremental encoder into a signed position count and a free-running raw count. All four lines are brought into the block's clock through a two-stage synchronizer. A, B and Index then pass through a hold-time glitch filter whose length can be switched between a long and a short setting. The filtered A and B lines are decoded either as a quadrature pair or as a step line with a direction line.

The position count can be cleared in two ways. A level-sensitive clear input holds it at zero. Software can also arm an index capture: the next qualified Index edge zeroes the position and drops the armed flag, and software reads the drop as proof that the capture happened. The active Index edge can be programmed. An optional qualifier input gates the edge, and the level at which the qualifier lets the edge through can also be programmed. The raw count follows every decoded step and is cleared only by the block reset.

A single write port loads a five-bit mode word. Scaling, velocity estimation and host bus protocols are handled outside the block.

Top module: `qenc_counter`

## Requirements
- R1: After the synchronous reset `rst`, pos_count and raw_count are 0 and idx_armed is 0. The mode word holds the long filter, quadrature decoding, falling-edge index and masking off.
- R2: The mode word is loaded from cfg_wdata when cfg_we is high. With bit 1 (long filter) set, a change on A, B or Index counts only after its synchronized level has held for 15 consecutive clocks. A pulse of 14 clocks has no effect.
- R3: With mode bit 1 clear, a change counts after 3 consecutive clocks. A pulse of 2 clocks has no effect.
- R4: With mode bit 0 clear (quadrature), the {A,B} sequence 00→10→11→01→00 adds 1 per transition and the reverse sequence subtracts 1. A jump in which both bits change at once is ignored.
- R5: With mode bit 0 set (step/direction), each rising edge of A adds 1 when B is high and subtracts 1 when B is low. Falling edges of A and any change on B do not count.
- R6: Mode bit 2 selects the active Index edge: 1 for rising, 0 for falling. The other edge has no effect.
- R7: With mode bit 3 set, an Index edge is qualified only while the mask input sits at its enabling level. That level is high when mode bit 4 is 0 and low when mode bit 4 is 1. With bit 3 clear, the mask input is ignored.
- R8: A one-cycle pulse on idx_arm sets idx_armed. A qualified Index edge while armed sets pos_count to 0 and clears idx_armed in the same cycle. Index edges while disarmed leave pos_count unchanged.
- R9: While pos_clear is high, pos_count reads 0. After pos_clear is released, counting continues from 0.
- R10: raw_count follows every decoded step. It is not affected by pos_clear or by an index clear.
- R11: Both counts are 32-bit two's complement and wrap, so one down step from 0 reads 32'hFFFF_FFFF.
- R12: When an index clear and a decoded step fall in the same cycle, pos_count becomes 0 and raw_count still takes the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Encoder A line, or step in step/direction mode |
| in_b | input | 1 | Encoder B line, or direction in step/direction mode |
| in_idx | input | 1 | Index line |
| in_idx_mask | input | 1 | Index qualifier line |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 5 | Mode word: bit0 step/dir, bit1 long filter, bit2 rising index, bit3 mask enable, bit4 mask active low |
| idx_arm | input | 1 | Pulse that arms the index capture |
| pos_clear | input | 1 | Holds the position count at zero |
| idx_armed | output | 1 | Index capture armed; drops when a capture occurs |
| pos_count | output | 32 | Signed position count |
| raw_count | output | 32 | Signed count that never clears after reset |

## Verification
An index clear and a counting step can land in the same cycle. The bench provokes this by changing A and Index in the same clock, with the capture armed and the rising edge selected. Because both lines pass through identical filters, the two events leave the filter together. The result passes if pos_count reads 0, idx_armed drops, and raw_count has still moved by one. The same overlap is tested for pos_clear, which is held high while quadrature steps continue.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Mode word; bit 0 is the LSB of cfg_wdata.
    typedef struct packed {
        logic mask_low;   // bit 4: qualifier enables when low
        logic mask_en;    // bit 3: qualifier in use
        logic idx_rise;   // bit 2: rising index edge
        logic filt_long;  // bit 1: long hold filter
        logic step_dir;   // bit 0: step/direction decoding
    } qenc_cfg_t;

    localparam int CFG_W = $bits(qenc_cfg_t);

    localparam qenc_cfg_t CFG_RESET = '{
        mask_low:  1'b0,
        mask_en:   1'b0,
        idx_rise:  1'b0,
        filt_long: 1'b1,
        step_dir:  1'b0
    };

    typedef enum logic [1:0] {
        MOVE_NONE = 2'b00,
        MOVE_UP   = 2'b01,
        MOVE_DOWN = 2'b10
    } move_e;

    // {A,B} old and new; A leading B counts up.
    function automatic move_e quad_move(input logic [1:0] prev, input logic [1:0] cur);
        move_e m;
        case ({prev, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: m = MOVE_UP;
            4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: m = MOVE_DOWN;
            default:                                m = MOVE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int LONG_HOLD  = 15,
    parameter int SHORT_HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic long_sel,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LONG_HOLD + 1);

    logic [CW-1:0] run;
    logic [CW-1:0] limit;

    assign limit = long_sel ? CW'(LONG_HOLD - 1) : CW'(SHORT_HOLD - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            dout <= 1'b0;
        end else if (din == dout) begin
            run <= '0;
        end else if (run >= limit) begin
            dout <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_dir,
    input  logic  a,
    input  logic  b,
    output move_e move
);
    logic prev_a;
    logic prev_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= a;
            prev_b <= b;
        end
    end

    always_comb begin
        if (step_dir) begin
            if (a && !prev_a) move = b ? MOVE_UP : MOVE_DOWN;
            else              move = MOVE_NONE;
        end else begin
            move = quad_move({prev_a, prev_b}, {a, b});
        end
    end
endmodule

// File: rtl/qenc_index.sv
module qenc_index (
    input  logic clk,
    input  logic rst,
    input  logic idx,
    input  logic mask,
    input  logic idx_rise,
    input  logic mask_en,
    input  logic mask_low,
    input  logic arm_req,
    output logic hit,
    output logic armed
);
    logic prev_idx;
    logic edge_seen;
    logic qualified;

    always_ff @(posedge clk) begin
        if (rst) prev_idx <= 1'b0;
        else     prev_idx <= idx;
    end

    assign edge_seen = idx_rise ? (idx && !prev_idx) : (!idx && prev_idx);
    assign qualified = !mask_en || (mask != mask_low);
    assign hit       = edge_seen && qualified && armed;

    always_ff @(posedge clk) begin
        if (rst)          armed <= 1'b0;
        else if (hit)     armed <= 1'b0;
        else if (arm_req) armed <= 1'b1;
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int LONG_HOLD  = 15,
    parameter int SHORT_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             in_idx,
    input  logic             in_idx_mask,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             idx_arm,
    input  logic             pos_clear,
    output logic             idx_armed,
    output logic [CNT_W-1:0] pos_count,
    output logic [CNT_W-1:0] raw_count
);
    localparam int N_FILT = 3;              // A, B, Index
    localparam int N_SYNC = N_FILT + 1;     // plus the qualifier
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    qenc_cfg_t         cfg;
    logic [N_SYNC-1:0] sync_q;
    logic [N_FILT-1:0] filt_q;
    move_e             move;
    logic              idx_hit;

    always_ff @(posedge clk) begin
        if (rst)         cfg <= CFG_RESET;
        else if (cfg_we) cfg <= qenc_cfg_t'(cfg_wdata);
    end

    qenc_sync #(.W(N_SYNC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({in_idx_mask, in_idx, in_b, in_a}),
        .d_sync  (sync_q)
    );

    for (genvar gi = 0; gi < N_FILT; gi++) begin : g_filt
        qenc_filter #(
            .LONG_HOLD  (LONG_HOLD),
            .SHORT_HOLD (SHORT_HOLD)
        ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .long_sel (cfg.filt_long),
            .din      (sync_q[gi]),
            .dout     (filt_q[gi])
        );
    end

    qenc_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .step_dir (cfg.step_dir),
        .a        (filt_q[0]),
        .b        (filt_q[1]),
        .move     (move)
    );

    qenc_index u_index (
        .clk      (clk),
        .rst      (rst),
        .idx      (filt_q[2]),
        .mask     (sync_q[3]),
        .idx_rise (cfg.idx_rise),
        .mask_en  (cfg.mask_en),
        .mask_low (cfg.mask_low),
        .arm_req  (idx_arm),
        .hit      (idx_hit),
        .armed    (idx_armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_count <= '0;
            pos_count <= '0;
        end else begin
            case (move)
                MOVE_UP:   raw_count <= raw_count + ONE;
                MOVE_DOWN: raw_count <= raw_count - ONE;
                default:   raw_count <= raw_count;
            endcase
            if (pos_clear || idx_hit) begin
                pos_count <= '0;
            end else begin
                case (move)
                    MOVE_UP:   pos_count <= pos_count + ONE;
                    MOVE_DOWN: pos_count <= pos_count - ONE;
                    default:   pos_count <= pos_count;
                endcase
            end
        end
    end
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             idx_arm,
    input logic             pos_clear,
    input logic             idx_armed,
    input logic [CNT_W-1:0] pos_count,
    input logic [CNT_W-1:0] raw_count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R8: the armed flag only rises after a request
    a_r8_arm_needs_request: assert property (@(posedge clk) disable iff (rst)
        $rose(idx_armed) |-> $past(idx_arm));

    // R8: a disarm coincides with a zeroed position
    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(idx_armed) |-> (pos_count == '0));

    // R9: clear input forces zero on the next cycle
    a_r9_clear_holds: assert property (@(posedge clk) disable iff (rst)
        pos_clear |=> (pos_count == '0));

    // R10: raw count moves by at most one per cycle and never jumps to zero otherwise
    a_r10_raw_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw_count == $past(raw_count) ||
                  raw_count == $past(raw_count) + ONE ||
                  raw_count == $past(raw_count) - ONE));

    // R4: position moves by one or drops to zero
    a_r4_pos_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pos_count == $past(pos_count) ||
                  pos_count == $past(pos_count) + ONE ||
                  pos_count == $past(pos_count) - ONE ||
                  pos_count == '0));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .idx_arm   (idx_arm),
    .pos_clear (pos_clear),
    .idx_armed (idx_armed),
    .pos_count (pos_count),
    .raw_count (raw_count)
);

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;
    import qenc_pkg::*;

    localparam int CNT_W  = 32;
    localparam int SETTLE = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0, in_idx_mask = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             idx_arm = 1'b0;
    logic             pos_clear = 1'b0;
    logic             idx_armed;
    logic [CNT_W-1:0] pos_count, raw_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_pos = '0, exp_raw = '0;
    logic        exp_armed = 1'b0;
    logic        clr_on = 1'b0;
    qenc_cfg_t   cur_cfg = CFG_RESET;

    always #4 clk = ~clk;

    qenc_counter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
        .in_idx_mask(in_idx_mask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .idx_arm(idx_arm), .pos_clear(pos_clear), .idx_armed(idx_armed),
        .pos_count(pos_count), .raw_count(raw_count)
    );

    function automatic int gray_pos(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] gray_ab(input int p);
        case (p)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int exp_delta(input qenc_cfg_t c, input logic [1:0] p, input logic [1:0] n);
        int d;
        if (c.step_dir) return (!p[1] && n[1]) ? (n[0] ? 1 : -1) : 0;
        d = (gray_pos(n) - gray_pos(p) + 4) % 4;
        if (d == 1) return 1;
        if (d == 3) return -1;
        return 0;
    endfunction

    function automatic logic exp_hit(input qenc_cfg_t c, input logic pi, input logic ni,
                                     input logic m, input logic armed);
        logic e, q;
        e = c.idx_rise ? (ni && !pi) : (!ni && pi);
        q = !c.mask_en || (c.mask_low ? !m : m);
        return e && q && armed;
    endfunction

    function automatic qenc_cfg_t mkcfg(input logic sd, input logic fl, input logic ir,
                                        input logic me, input logic ml);
        qenc_cfg_t c;
        c.step_dir = sd; c.filt_long = fl; c.idx_rise = ir; c.mask_en = me; c.mask_low = ml;
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, pos_count, exp_pos);
        chk({req, "/R10 raw"}, raw_count, exp_raw);
        chk({req, "/R8 armed"}, {31'd0, idx_armed}, {31'd0, exp_armed});
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic a, input logic b, input logic idx, input logic m);
        int d;
        logic h;
        @(posedge clk); #1;
        d = exp_delta(cur_cfg, {in_a, in_b}, {a, b});
        h = exp_hit(cur_cfg, in_idx, idx, m, exp_armed);
        in_a = a; in_b = b; in_idx = idx; in_idx_mask = m;
        exp_raw = exp_raw + 32'(d);
        if (h) begin
            exp_pos = '0;
            exp_armed = 1'b0;
        end else begin
            exp_pos = exp_pos + 32'(d);
        end
        if (clr_on) exp_pos = '0;
        settle();
    endtask

    task automatic quad_step(input int dir);
        logic [1:0] nx;
        nx = gray_ab((gray_pos({in_a, in_b}) + dir + 4) % 4);
        apply(nx[1], nx[0], in_idx, in_idx_mask);
    endtask

    task automatic wcfg(input qenc_cfg_t c);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = c;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        cur_cfg = c;
        @(negedge clk);
    endtask

    task automatic arm();
        @(posedge clk); #1 idx_arm = 1'b1;
        @(posedge clk); #1 idx_arm = 1'b0;
        exp_armed = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_clear(input logic v);
        @(posedge clk); #1 pos_clear = v;
        clr_on = v;
        if (v) exp_pos = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // A pulse on A of exactly w clocks, then back to its old level
    task automatic glitch_a(input int w, input logic passes);
        @(posedge clk); #1 in_a = ~in_a;
        repeat (w) @(posedge clk);
        #1 in_a = ~in_a;
        if (passes) begin
            exp_raw = exp_raw + (in_b ? 32'd1 : 32'hFFFF_FFFF);
            exp_pos = exp_pos + (in_b ? 32'd1 : 32'hFFFF_FFFF);
        end
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R4: random quadrature walk with the long filter (default)
        for (int i = 0; i < 120; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) apply(~in_a, ~in_b, in_idx, in_idx_mask);
            else        quad_step((r < 5) ? 1 : -1);
            check_all("R4 quad random");
        end
        apply(~in_a, ~in_b, in_idx, in_idx_mask);
        check_all("R4 illegal jump");

        // R3: short filter walk
        wcfg(mkcfg(0, 0, 0, 0, 0));
        for (int i = 0; i < 40; i++) begin
            quad_step(($urandom % 2) ? 1 : -1);
            check_all("R3 quad short filter");
        end

        // R5: step/direction
        wcfg(mkcfg(1, 0, 0, 0, 0));
        apply(0, 1, in_idx, in_idx_mask); check_all("R5 setup");
        apply(1, 1, in_idx, in_idx_mask); check_all("R5 up step");
        apply(0, 1, in_idx, in_idx_mask); check_all("R5 falling ignored");
        apply(0, 0, in_idx, in_idx_mask); check_all("R5 dir change ignored");
        apply(1, 0, in_idx, in_idx_mask); check_all("R5 down step");
        apply(0, 1, in_idx, in_idx_mask); check_all("R5 back");

        // R3 and R2: glitch rejection thresholds (A low, B high)
        glitch_a(2, 1'b0);  check_all("R3 2-clock pulse rejected");
        glitch_a(3, 1'b1);  check_all("R3 3-clock pulse counted");
        wcfg(mkcfg(1, 1, 0, 0, 0));
        glitch_a(14, 1'b0); check_all("R2 14-clock pulse rejected");
        glitch_a(15, 1'b1); check_all("R2 15-clock pulse counted");

        // R6/R8: falling-edge index
        wcfg(mkcfg(0, 1, 0, 0, 0));
        quad_step(1); quad_step(1);
        apply(in_a, in_b, 1, 0); apply(in_a, in_b, 0, 0);
        check_all("R8 disarmed index ignored");
        arm();
        check_all("R8 armed");
        apply(in_a, in_b, 1, 0); check_all("R6 rising ignored when falling selected");
        apply(in_a, in_b, 0, 0); check_all("R6 falling edge clears");
        quad_step(1); quad_step(1);
        wcfg(mkcfg(0, 1, 1, 0, 0));
        arm();
        apply(in_a, in_b, 1, 0); check_all("R6 rising edge clears");

        // R7: qualifier active high, then active low
        wcfg(mkcfg(0, 1, 1, 1, 0));
        quad_step(-1); quad_step(-1); quad_step(-1);
        apply(in_a, in_b, 0, 0);
        arm();
        apply(in_a, in_b, 1, 0); check_all("R7 blocked by low mask");
        apply(in_a, in_b, 0, 1);
        apply(in_a, in_b, 1, 1); check_all("R7 passed by high mask");
        wcfg(mkcfg(0, 1, 1, 1, 1));
        quad_step(1);
        apply(in_a, in_b, 0, 1);
        arm();
        apply(in_a, in_b, 1, 1); check_all("R7 inverted blocked by high mask");
        apply(in_a, in_b, 0, 0);
        apply(in_a, in_b, 1, 0); check_all("R7 inverted passed by low mask");

        // R9/R10: clear input holds position, raw keeps counting
        wcfg(mkcfg(0, 1, 1, 0, 0));
        quad_step(1); quad_step(1);
        set_clear(1'b1);
        for (int i = 0; i < 5; i++) begin
            quad_step(1);
            check_all("R9 held at zero");
        end
        set_clear(1'b0);
        quad_step(1); quad_step(1);
        check_all("R9 resumes from zero");

        // R11: wrap below zero
        set_clear(1'b1); set_clear(1'b0);
        quad_step(-1);
        chk("R11 wrap to -1", pos_count, 32'hFFFF_FFFF);
        check_all("R11 wrap");

        // R12: index clear and step in the same cycle
        quad_step(1); quad_step(1);
        apply(in_a, in_b, 0, 0);
        arm();
        begin
            logic [1:0] nx;
            nx = gray_ab((gray_pos({in_a, in_b}) + 1) % 4);
            apply(nx[1], nx[0], 1, 0);
        end
        chk("R12 pos cleared", pos_count, 32'd0);
        check_all("R12 coincident clear and step");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule